// File: doc/BRIEF.md
# Dual Smart Card Port and DMA Router

This block sits between two logical smart card channels, each with its own card UART, and the physical card sockets of the chip. Logical card 0 is fixed to the main card socket. Logical card 1 reaches one of several SIM sockets through an external interface device, and a select register picks which one. Every socket that is not in use has its clock held low and its data line held high. The block passes the data returning from the live socket back to the logical card that owns it.

The same block steers two DMA request lines, one for receive and one for transmit, toward the logical cards. Each line has its own 2-bit mapping field, so receive can serve one card while transmit serves the other, or either can be left unused. A mapping code that would put both cards on one channel is refused: the block raises an error flag and blocks that channel. All outputs are registered, so every output lags its inputs by one clock.

Software writes three small configuration registers through a single-cycle write strobe with a 2-bit address. The DMA engine and the card UARTs are outside this block.

Top module: `cardrt_router`

## Requirements
- R1: After synchronous reset, both logical cards are inactive and the SIM select is 0. Both DMA mappings are 00 and `cfg_err` is 0. Every socket clock is 0, every socket data line is 1 and `lc_io_in` is all ones. The DMA requests and every card acknowledge are 0.
- R2: Address 0 bit 0 activates logical card 0. While it is set, `main_clk` and `main_io` follow `lc_clk[0]` and `lc_io[0]`. While it is clear, the main socket is idle.
- R3: Address 0 bit 1 activates logical card 1. While it is set, the SIM socket whose index equals the select value follows `lc_clk[1]` and `lc_io[1]`. Every other SIM socket is idle.
- R4: The idle level of an unused socket is clock 0 and data 1.
- R5: `lc_io_in[0]` returns `main_io_in` while card 0 is active and 1 otherwise. `lc_io_in[1]` returns `sim_io_in[sel]` while card 1 is active and 1 otherwise.
- R6: A write to address 1, bits [SEL_W-1:0], updates the SIM select only while card 1 is inactive. While card 1 is active the write is ignored, and card 1 stays on its current socket.
- R7: Address 2 holds the receive mapping in bits [1:0] and the transmit mapping in bits [3:2]. Code 01 picks card 0 and 10 picks card 1. The picked card's request drives the channel request, and the channel acknowledge goes back to that card's acknowledge bit only.
- R8: Mapping code 00 leaves a channel unassigned: its request is 0 and both card acknowledges for it are 0.
- R9: Mapping code 11 would put both cards on one channel. It sets the channel's error bit (`cfg_err[0]` for receive, `cfg_err[1]` for transmit), forces the request to 0 and the acknowledges to 0. The error bit clears once a legal code is written.
- R10: The receive and transmit mappings act independently. Each may pick a different card, the same card, or none.
- R11: Every output is registered. A change of input or configuration shows at the outputs one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register address: 0 activation, 1 SIM select, 2 DMA mapping |
| cfg_wdata | input | CFG_W | Write data |
| lc_clk | input | 2 | Card clock from each logical card UART |
| lc_io | input | 2 | Card data out from each logical card UART |
| lc_io_in | output | 2 | Card data returned to each logical card |
| main_clk | output | 1 | Main socket clock |
| main_io | output | 1 | Main socket data out |
| main_io_in | input | 1 | Main socket data in |
| sim_clk | output | N_SIM | SIM socket clocks |
| sim_io | output | N_SIM | SIM socket data out |
| sim_io_in | input | N_SIM | SIM socket data in |
| lc_rx_req | input | 2 | Receive DMA request from each logical card |
| lc_tx_req | input | 2 | Transmit DMA request from each logical card |
| lc_rx_ack | output | 2 | Receive DMA acknowledge to each logical card |
| lc_tx_ack | output | 2 | Transmit DMA acknowledge to each logical card |
| dma_rx_req | output | 1 | Request to the receive DMA channel |
| dma_tx_req | output | 1 | Request to the transmit DMA channel |
| dma_rx_ack | input | 1 | Acknowledge from the receive DMA channel |
| dma_tx_ack | input | 1 | Acknowledge from the transmit DMA channel |
| cfg_err | output | 2 | Illegal-mapping flags, bit 0 receive, bit 1 transmit |

## Verification
The bench tries to change the SIM select while card 1 is active. A design that accepted that write would move card 1's clock to a different socket in the middle of a session. It programs the reserved mapping code 11. A design that decoded it as a card would leak a request to the DMA engine and send acknowledges to both cards. It maps receive and transmit to different cards and to no card, which exposes any cross-coupling between the two channels. Random traffic with random configuration writes then checks every output cycle by cycle. This catches an extra or missing register stage, and a socket that is released from its idle level while it is not selected.

// File: rtl/cardrt_pkg.sv
package cardrt_pkg;
  localparam logic [1:0] ADDR_ACT = 2'd0;
  localparam logic [1:0] ADDR_SEL = 2'd1;
  localparam logic [1:0] ADDR_MAP = 2'd2;

  localparam logic [1:0] MAP_NONE = 2'b00;
  localparam logic [1:0] MAP_C0   = 2'b01;
  localparam logic [1:0] MAP_C1   = 2'b10;
  localparam logic [1:0] MAP_BAD  = 2'b11;

  localparam int N_LC = 2;
  localparam int N_CH = 2;
endpackage

// File: rtl/cardrt_cfg_regs.sv
module cardrt_cfg_regs
  import cardrt_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output logic             act0,
  output logic             act1,
  output logic [SEL_W-1:0] sel,
  output logic [1:0]       rx_map,
  output logic [1:0]       tx_map
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act0   <= 1'b0;
      act1   <= 1'b0;
      sel    <= '0;
      rx_map <= MAP_NONE;
      tx_map <= MAP_NONE;
    end else if (we) begin
      case (addr)
        ADDR_ACT: begin
          act0 <= wdata[0];
          act1 <= wdata[1];
        end
        ADDR_SEL: begin
          // the select is frozen while logical card 1 is live
          if (!act1) sel <= wdata[SEL_W-1:0];
        end
        ADDR_MAP: begin
          rx_map <= wdata[1:0];
          tx_map <= wdata[3:2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cardrt_port_mux.sv
module cardrt_port_mux #(
  parameter int N_SIM = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act0,
  input  logic             act1,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       lc_clk,
  input  logic [1:0]       lc_io,
  output logic [1:0]       lc_io_in,
  output logic             main_clk,
  output logic             main_io,
  input  logic             main_io_in,
  output logic [N_SIM-1:0] sim_clk,
  output logic [N_SIM-1:0] sim_io,
  input  logic [N_SIM-1:0] sim_io_in
);
  logic sim_ret;

  always_comb begin
    sim_ret = 1'b1;
    for (int i = 0; i < N_SIM; i++) begin
      if (sel == SEL_W'(i)) sim_ret = sim_io_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_clk <= 1'b0;
      main_io  <= 1'b1;
      lc_io_in <= 2'b11;
    end else begin
      main_clk    <= act0 & lc_clk[0];
      main_io     <= act0 ? lc_io[0] : 1'b1;
      lc_io_in[0] <= act0 ? main_io_in : 1'b1;
      lc_io_in[1] <= act1 ? sim_ret : 1'b1;
    end
  end

  for (genvar g = 0; g < N_SIM; g++) begin : g_sim
    logic hit;
    assign hit = act1 && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        sim_clk[g] <= 1'b0;
        sim_io[g]  <= 1'b1;
      end else begin
        sim_clk[g] <= hit & lc_clk[1];
        sim_io[g]  <= hit ? lc_io[1] : 1'b1;
      end
    end
  end
endmodule

// File: rtl/cardrt_dma_lane.sv
module cardrt_dma_lane
  import cardrt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] map,
  input  logic [1:0] lc_req,
  input  logic       ch_ack,
  output logic       ch_req,
  output logic [1:0] lc_ack,
  output logic       err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_req <= 1'b0;
      lc_ack <= 2'b00;
      err    <= 1'b0;
    end else begin
      err <= (map == MAP_BAD);
      case (map)
        MAP_C0: begin
          ch_req <= lc_req[0];
          lc_ack <= {1'b0, ch_ack};
        end
        MAP_C1: begin
          ch_req <= lc_req[1];
          lc_ack <= {ch_ack, 1'b0};
        end
        default: begin
          ch_req <= 1'b0;
          lc_ack <= 2'b00;
        end
      endcase
    end
  end
endmodule

// File: rtl/cardrt_router.sv
module cardrt_router
  import cardrt_pkg::*;
#(
  parameter  int N_SIM = 4,
  localparam int SEL_W = (N_SIM > 1) ? $clog2(N_SIM) : 1,
  localparam int CFG_W = (SEL_W > 4) ? SEL_W : 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [1:0]       lc_clk,
  input  logic [1:0]       lc_io,
  output logic [1:0]       lc_io_in,
  output logic             main_clk,
  output logic             main_io,
  input  logic             main_io_in,
  output logic [N_SIM-1:0] sim_clk,
  output logic [N_SIM-1:0] sim_io,
  input  logic [N_SIM-1:0] sim_io_in,
  input  logic [1:0]       lc_rx_req,
  input  logic [1:0]       lc_tx_req,
  output logic [1:0]       lc_rx_ack,
  output logic [1:0]       lc_tx_ack,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  input  logic             dma_rx_ack,
  input  logic             dma_tx_ack,
  output logic [1:0]       cfg_err
);
  logic             act0_q, act1_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       rx_map_q, tx_map_q;

  cardrt_cfg_regs #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .act0(act0_q), .act1(act1_q), .sel(sel_q),
    .rx_map(rx_map_q), .tx_map(tx_map_q)
  );

  cardrt_port_mux #(.N_SIM(N_SIM), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .act0(act0_q), .act1(act1_q), .sel(sel_q),
    .lc_clk(lc_clk), .lc_io(lc_io), .lc_io_in(lc_io_in),
    .main_clk(main_clk), .main_io(main_io), .main_io_in(main_io_in),
    .sim_clk(sim_clk), .sim_io(sim_io), .sim_io_in(sim_io_in)
  );

  // channel 0 is receive, channel 1 is transmit
  logic [N_CH-1:0][1:0] ch_map, ch_lc_req, ch_lc_ack;
  logic [N_CH-1:0]      ch_ack, ch_req;

  assign ch_map    = {tx_map_q, rx_map_q};
  assign ch_lc_req = {lc_tx_req, lc_rx_req};
  assign ch_ack    = {dma_tx_ack, dma_rx_ack};

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    cardrt_dma_lane u_lane (
      .clk(clk), .rst(rst), .map(ch_map[c]), .lc_req(ch_lc_req[c]),
      .ch_ack(ch_ack[c]), .ch_req(ch_req[c]), .lc_ack(ch_lc_ack[c]),
      .err(cfg_err[c])
    );
  end

  assign dma_rx_req = ch_req[0];
  assign dma_tx_req = ch_req[1];
  assign lc_rx_ack  = ch_lc_ack[0];
  assign lc_tx_ack  = ch_lc_ack[1];
endmodule

// File: rtl/cardrt_router_chk.sv
module cardrt_router_chk #(
  parameter int N_SIM = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             act0_q,
  input logic             act1_q,
  input logic [SEL_W-1:0] sel_q,
  input logic [1:0]       rx_map_q,
  input logic [1:0]       tx_map_q,
  input logic [1:0]       lc_clk,
  input logic             main_clk,
  input logic [N_SIM-1:0] sim_clk,
  input logic [N_SIM-1:0] sim_io,
  input logic [1:0]       lc_io_in,
  input logic             dma_rx_req,
  input logic             dma_tx_req,
  input logic [1:0]       lc_rx_ack,
  input logic [1:0]       lc_tx_ack,
  input logic [1:0]       cfg_err
);
  p_reset_cfg_r1: assert property (@(posedge clk)
    rst |=> (!act0_q && !act1_q && sel_q == '0 && rx_map_q == 2'b00 && tx_map_q == 2'b00));

  p_main_follow_r2: assert property (@(posedge clk) disable iff (rst)
    act0_q |=> (main_clk == $past(lc_clk[0])));

  for (genvar g = 0; g < N_SIM; g++) begin : g_idle
    p_sim_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (!act1_q || sel_q != SEL_W'(g)) |=> (sim_clk[g] == 1'b0 && sim_io[g] == 1'b1));
  end

  p_ret_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !act1_q |=> lc_io_in[1]);

  p_sel_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (act1_q && cfg_we && cfg_addr == 2'd1) |=> $stable(sel_q));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_map_q == 2'b00) |=> (!dma_rx_req && lc_rx_ack == 2'b00));

  p_bad_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_map_q == 2'b11) |=> (cfg_err[0] && !dma_rx_req && lc_rx_ack == 2'b00));

  p_bad_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_map_q == 2'b11) |=> (cfg_err[1] && !dma_tx_req && lc_tx_ack == 2'b00));

  p_tx_ack_one_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lc_tx_ack));
endmodule

bind cardrt_router cardrt_router_chk #(.N_SIM(N_SIM), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .act0_q(act0_q), .act1_q(act1_q), .sel_q(sel_q),
  .rx_map_q(rx_map_q), .tx_map_q(tx_map_q),
  .lc_clk(lc_clk), .main_clk(main_clk), .sim_clk(sim_clk), .sim_io(sim_io),
  .lc_io_in(lc_io_in), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
  .lc_rx_ack(lc_rx_ack), .lc_tx_ack(lc_tx_ack), .cfg_err(cfg_err)
);

// File: tb/cardrt_router_tb.sv
`timescale 1ns/1ps
module cardrt_router_tb;
  localparam int N_SIM = 4;
  localparam int SEL_W = 2;
  localparam int CFG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [1:0] lc_clk = '0, lc_io = '0, lc_rx_req = '0, lc_tx_req = '0;
  logic main_io_in = 1'b0, dma_rx_ack = 1'b0, dma_tx_ack = 1'b0;
  logic [N_SIM-1:0] sim_io_in = '0;
  logic [1:0] lc_io_in, lc_rx_ack, lc_tx_ack, cfg_err;
  logic main_clk, main_io, dma_rx_req, dma_tx_req;
  logic [N_SIM-1:0] sim_clk, sim_io;

  cardrt_router #(.N_SIM(N_SIM)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lc_clk(lc_clk), .lc_io(lc_io), .lc_io_in(lc_io_in),
    .main_clk(main_clk), .main_io(main_io), .main_io_in(main_io_in),
    .sim_clk(sim_clk), .sim_io(sim_io), .sim_io_in(sim_io_in),
    .lc_rx_req(lc_rx_req), .lc_tx_req(lc_tx_req),
    .lc_rx_ack(lc_rx_ack), .lc_tx_ack(lc_tx_ack),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .dma_rx_ack(dma_rx_ack), .dma_tx_ack(dma_tx_ack), .cfg_err(cfg_err)
  );

  initial forever #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the configuration registers
  bit m_act0, m_act1;
  logic [SEL_W-1:0] m_sel;
  logic [1:0] m_rx, m_tx;

  // expected outputs for the next sampling point
  logic e_main_clk, e_main_io, e_rx_req, e_tx_req;
  logic [N_SIM-1:0] e_sim_clk, e_sim_io;
  logic [1:0] e_lc_io_in, e_rx_ack, e_tx_ack, e_err;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic map_req(input logic [1:0] m, input logic [1:0] r);
    return (m == 2'b01) ? r[0] : (m == 2'b10) ? r[1] : 1'b0;
  endfunction

  function automatic logic [1:0] map_ack(input logic [1:0] m, input logic a);
    return (m == 2'b01) ? {1'b0, a} : (m == 2'b10) ? {a, 1'b0} : 2'b00;
  endfunction

  task automatic check_outputs();
    chk("R2/R11 main_clk", 32'(main_clk), 32'(e_main_clk));
    chk("R2/R4 main_io", 32'(main_io), 32'(e_main_io));
    chk("R3/R4 sim_clk", 32'(sim_clk), 32'(e_sim_clk));
    chk("R3/R4 sim_io", 32'(sim_io), 32'(e_sim_io));
    chk("R5 lc_io_in", 32'(lc_io_in), 32'(e_lc_io_in));
    chk("R7/R8/R10 dma_rx_req", 32'(dma_rx_req), 32'(e_rx_req));
    chk("R7/R8/R10 dma_tx_req", 32'(dma_tx_req), 32'(e_tx_req));
    chk("R7/R8 lc_rx_ack", 32'(lc_rx_ack), 32'(e_rx_ack));
    chk("R7/R8 lc_tx_ack", 32'(lc_tx_ack), 32'(e_tx_ack));
    chk("R9 cfg_err", 32'(cfg_err), 32'(e_err));
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [CFG_W-1:0] d);
    @(negedge clk);
    check_outputs();
    lc_clk     = 2'($urandom);
    lc_io      = 2'($urandom);
    lc_rx_req  = 2'($urandom);
    lc_tx_req  = 2'($urandom);
    main_io_in = 1'($urandom);
    sim_io_in  = N_SIM'($urandom);
    dma_rx_ack = 1'($urandom);
    dma_tx_ack = 1'($urandom);
    e_main_clk = m_act0 & lc_clk[0];
    e_main_io  = m_act0 ? lc_io[0] : 1'b1;
    for (int i = 0; i < N_SIM; i++) begin
      e_sim_clk[i] = (m_act1 && m_sel == SEL_W'(i)) ? lc_clk[1] : 1'b0;
      e_sim_io[i]  = (m_act1 && m_sel == SEL_W'(i)) ? lc_io[1] : 1'b1;
    end
    e_lc_io_in[0] = m_act0 ? main_io_in : 1'b1;
    e_lc_io_in[1] = m_act1 ? sim_io_in[m_sel] : 1'b1;
    e_rx_req = map_req(m_rx, lc_rx_req);
    e_tx_req = map_req(m_tx, lc_tx_req);
    e_rx_ack = map_ack(m_rx, dma_rx_ack);
    e_tx_ack = map_ack(m_tx, dma_tx_ack);
    e_err    = {m_tx == 2'b11, m_rx == 2'b11};
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    if (we) begin
      case (a)
        2'd0: begin m_act0 = d[0]; m_act1 = d[1]; end
        2'd1: if (!m_act1) m_sel = d[SEL_W-1:0];
        2'd2: begin m_rx = d[1:0]; m_tx = d[3:2]; end
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_act0 = 0; m_act1 = 0; m_sel = '0; m_rx = '0; m_tx = '0;
    e_main_clk = 0; e_main_io = 1; e_sim_clk = '0; e_sim_io = '1;
    e_lc_io_in = 2'b11; e_rx_req = 0; e_tx_req = 0;
    e_rx_ack = 0; e_tx_ack = 0; e_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle levels straight out of reset
    chk("R1 sim_io idle", 32'(sim_io), 32'({N_SIM{1'b1}}));
    chk("R1 main_io idle", 32'(main_io), 32'd1);
    chk("R1 lc_io_in", 32'(lc_io_in), 32'd3);
    chk("R1 cfg_err", 32'(cfg_err), 32'd0);
    chk("R1 dma reqs", 32'({dma_rx_req, dma_tx_req}), 32'd0);
    idle(4);

    // R2/R3: activate both cards, SIM index 2
    step(1'b1, 2'd1, 4'd2);
    step(1'b1, 2'd0, 4'b0011);
    idle(6);
    // R6: select write while card 1 is live must leave it on SIM 2
    step(1'b1, 2'd1, 4'd1);
    idle(6);
    // R6: deactivate, move to SIM 3, reactivate
    step(1'b1, 2'd0, 4'b0001);
    step(1'b1, 2'd1, 4'd3);
    step(1'b1, 2'd0, 4'b0011);
    idle(6);
    // R10: receive to card 1, transmit to card 0
    step(1'b1, 2'd2, 4'b0110);
    idle(8);
    // R9: receive uses the reserved code, transmit unassigned (R8)
    step(1'b1, 2'd2, 4'b0011);
    idle(6);
    // R9: clear by writing a legal code, both to card 1
    step(1'b1, 2'd2, 4'b1010);
    idle(6);
    // R9 on transmit while receive is on card 0
    step(1'b1, 2'd2, 4'b1101);
    idle(6);

    // random traffic with random configuration writes
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 4) == 0) step(1'b1, 2'($urandom), CFG_W'($urandom));
      else step(1'b0, 2'd0, '0);
    end
    @(negedge clk);
    check_outputs();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule